// File: doc/BRIEF.md
# Serial Audio Frame Capture Unit

This block receives a compressed Layer 1 audio bitstream one bit per clock cycle, MSB of each byte first, with the clock running at the stream bit rate. It hunts for the frame sync pattern, checks the layer code and the rate fields of the 32-bit header, and works out the frame length from them. It then stores every byte of the frame in a two-bank frame buffer. When the last bit of the frame has arrived, the filled bank is handed to the reader and the `frame_toggle` level is inverted. A decoding process running on its own timing detects the change and reads the frame through a one-cycle-latency byte port while the next frame is written into the other bank.

When the header's protection bit is clear, a 16-bit check word follows the header. The block runs a CRC over the second half of the header and over the bit-allocation field, compares the result with that word, and reports a mismatch on `crc_err` together with the frame's toggle.

The capture engine is one state machine with five states. `HUNT` counts consecutive ones. `HDR` takes header bits 12 to 31 and validates the layer and rate fields. `CHK` takes the 16-bit check word. `ALLOC` takes the bit-allocation field. `BODY` takes the rest of the frame.

Its named transitions are:
- *sync_found* (`HUNT`→`HDR`): the 12th one in a row arrives.
- *layer_reject* (`HDR`→`HUNT`): header bit 14 arrives and the layer code is not Layer 1.
- *format_reject* (`HDR`→`HUNT`): header bit 22 arrives and the rate fields are illegal.
- *header_done_protected* (`HDR`→`CHK`): the header ends and the protection bit is 0.
- *header_done_plain* (`HDR`→`ALLOC`): the header ends and the protection bit is 1.
- *check_done* (`CHK`→`ALLOC`): the last check-word bit arrives.
- *alloc_done* (`ALLOC`→`BODY`): the last allocation bit arrives.
- *frame_done* (`BODY`→`HUNT`): the last bit of the frame arrives.

Top module: `audio_frame_capture`

## Requirements
- R1: After reset `frame_toggle` = 0, `crc_err` = 0 and `frame_bytes` = 0.
- R2: A frame starts after 12 consecutive one bits (stream bits 0..11 of the frame). `frame_toggle` inverts on the same clock edge that samples the frame's last bit, once per frame.
- R3: Frame bytes are 4*floor(12*kbps*1000/fs) + 4*pad. Here kbps = 32*(bitrate field, header bits 16..19), fs is chosen by header bits 20..21 (0 = 44100, 1 = 48000, 2 = 32000) and pad is header bit 22. `frame_bytes` holds this value for the last frame captured.
- R4: `rd_data` is the byte at `rd_addr` of the last completed frame, one cycle after `rd_addr` is applied. Byte 0 is the first byte of the frame, and the first bit received in a byte is its bit 7.
- R5: If header bits 13..14 are not 2'b11 (Layer 1), the frame is dropped with no toggle, and hunting restarts from the next bit.
- R6: A bitrate field of 0 or 15, or a rate code of 3, drops the frame with no toggle.
- R7: When header bit 15 is 0, bits 32..47 hold a check word. A CRC with polynomial 0x8005, preset 0xFFFF, MSB first, runs over header bits 16..31 and the ALLOC_BITS allocation bits that follow the check word. `crc_err` is 1 exactly when the result differs from the check word, and it is updated together with the toggle.
- R8: When header bit 15 is 1 there is no check word, allocation starts at bit 32, and `crc_err` is 0 for that frame.
- R9: Frames may follow each other with no gap. While one frame is being captured, the previous frame stays readable unchanged.
- R10: Hunting after a frame starts with a count of zero, so one bits at the end of a frame do not shift the detection of the next sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock; one stream bit per rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_in | input | 1 | Serial stream bit |
| rd_addr | input | AW (10) | Byte address into the last completed frame |
| rd_data | output | 8 | Frame byte, one cycle after `rd_addr` |
| frame_toggle | output | 1 | Inverts when a frame is complete |
| crc_err | output | 1 | Check-word mismatch of the last frame |
| frame_bytes | output | AW (10) | Length in bytes of the last frame |

## Verification
The bench builds the block with its default parameters: a 1024-byte bank and a 128-bit allocation field. The largest legal frame (676 bytes at 448 kbit/s and 32 kHz) fits in a bank, and every bitrate and rate code, with and without padding, can be reached by the random frames. Directed frames cover bad layer and rate codes, good and corrupted check words, back-to-back frames with reads of the previous bank during capture, and frames that end in one bits right before the next sync.

// File: rtl/afc_pkg.sv
package afc_pkg;

    typedef enum logic [2:0] {
        S_HUNT,
        S_HDR,
        S_CHK,
        S_ALLOC,
        S_BODY
    } cap_state_t;

    localparam int          SYNC_ONES = 12;
    localparam int          HDR_BITS  = 32;
    localparam int          CHK_BITS  = 16;
    localparam logic [15:0] CRC_POLY  = 16'h8005;
    localparam logic [15:0] CRC_INIT  = 16'hFFFF;

    // Frame length in bytes without padding; 0 marks an illegal field pair.
    function automatic int unsigned slot_bytes(input int unsigned br_code,
                                               input int unsigned fs_code);
        int unsigned hz;
        if (br_code == 0 || br_code == 15 || fs_code == 3)
            return 0;
        hz = (fs_code == 0) ? 44100 : (fs_code == 1) ? 48000 : 32000;
        return 4 * ((12 * 32 * br_code * 1000) / hz);
    endfunction

endpackage

// File: rtl/afc_len_rom.sv
module afc_len_rom #(
    parameter int AW = 10
) (
    input  logic [3:0]    br_code,
    input  logic [1:0]    fs_code,
    input  logic          pad,
    output logic [AW-1:0] len_bytes,
    output logic          len_ok
);
    localparam int ENTRIES = 64;

    logic [AW-1:0] tbl [ENTRIES];

    for (genvar gb = 0; gb < 16; gb++) begin : g_br
        for (genvar gf = 0; gf < 4; gf++) begin : g_fs
            assign tbl[gb*4 + gf] = AW'(afc_pkg::slot_bytes(gb, gf));
        end
    end

    logic [AW-1:0] base;
    assign base      = tbl[{br_code, fs_code}];
    assign len_ok    = (base != '0);
    assign len_bytes = base + (pad ? AW'(4) : AW'(0));
endmodule

// File: rtl/afc_crc16.sv
module afc_crc16 (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        preset,
    input  logic        shift,
    input  logic        din,
    output logic [15:0] crc_next
);
    logic [15:0] crc_q;
    logic        fb;

    assign fb       = crc_q[15] ^ din;
    assign crc_next = {crc_q[14:0], 1'b0} ^ (fb ? afc_pkg::CRC_POLY : 16'h0000);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            crc_q <= afc_pkg::CRC_INIT;
        else if (preset)
            crc_q <= afc_pkg::CRC_INIT;
        else if (shift)
            crc_q <= crc_next;
    end
endmodule

// File: rtl/afc_pingpong_ram.sv
module afc_pingpong_ram #(
    parameter int BYTES = 1024,
    parameter int AW    = 10
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic          wr_bank,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic          rd_bank,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    localparam int DEPTH = 2 * BYTES;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en)
            mem[{wr_bank, wr_addr}] <= wr_data;
        rd_data <= mem[{rd_bank, rd_addr}];
    end
endmodule

// File: rtl/audio_frame_capture.sv
module audio_frame_capture #(
    parameter int BUF_BYTES  = 1024,
    parameter int ALLOC_BITS = 128
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bit_in,
    input  logic [$clog2(BUF_BYTES)-1:0] rd_addr,
    output logic [7:0]                   rd_data,
    output logic                         frame_toggle,
    output logic                         crc_err,
    output logic [$clog2(BUF_BYTES)-1:0] frame_bytes
);
    import afc_pkg::*;

    localparam int AW = $clog2(BUF_BYTES);
    localparam int BW = AW + 3;
    localparam logic [BW-1:0] IDX_LAYER  = BW'(14);
    localparam logic [BW-1:0] IDX_PROT   = BW'(15);
    localparam logic [BW-1:0] IDX_CRC0   = BW'(16);
    localparam logic [BW-1:0] IDX_PAD    = BW'(22);
    localparam logic [BW-1:0] IDX_HEND   = BW'(HDR_BITS - 1);
    localparam logic [BW-1:0] IDX_CEND   = BW'(HDR_BITS + CHK_BITS - 1);
    localparam logic [BW-1:0] IDX_AEND_P = BW'(HDR_BITS + ALLOC_BITS - 1);
    localparam logic [BW-1:0] IDX_AEND_C = BW'(HDR_BITS + CHK_BITS + ALLOC_BITS - 1);
    localparam logic [3:0]    ONES_LAST  = 4'(SYNC_ONES - 1);

    cap_state_t    state_q, state_d;
    logic [BW-1:0] bit_idx_q;
    logic [3:0]    ones_q;
    logic [6:0]    byte_q;
    logic          prot_q;
    logic [AW-1:0] len_q;
    logic [15:0]   chk_q;
    logic          crc_bad_q;
    logic          wr_bank_q;

    // event decode
    logic          sync_hit, layer_bad, fmt_bad, hdr_end, chk_end, alloc_end, frame_end;
    logic [BW-1:0] alloc_last, frame_last;
    logic [AW-1:0] len_bytes;
    logic          len_ok;
    logic [15:0]   crc_next;
    logic          crc_shift;

    afc_len_rom #(.AW(AW)) u_len (
        .br_code   (byte_q[5:2]),
        .fs_code   (byte_q[1:0]),
        .pad       (bit_in),
        .len_bytes (len_bytes),
        .len_ok    (len_ok)
    );

    assign crc_shift = ((state_q == S_HDR) && (bit_idx_q >= IDX_CRC0)) || (state_q == S_ALLOC);

    afc_crc16 u_crc (
        .clk      (clk),
        .rst_n    (rst_n),
        .preset   (sync_hit),
        .shift    (crc_shift),
        .din      (bit_in),
        .crc_next (crc_next)
    );

    assign alloc_last = prot_q ? IDX_AEND_P : IDX_AEND_C;
    assign frame_last = {len_q - AW'(1), 3'b111};

    assign sync_hit  = (state_q == S_HUNT) && bit_in && (ones_q == ONES_LAST);
    assign layer_bad = (state_q == S_HDR) && (bit_idx_q == IDX_LAYER) && ({byte_q[0], bit_in} != 2'b11);
    assign fmt_bad   = (state_q == S_HDR) && (bit_idx_q == IDX_PAD) && !len_ok;
    assign hdr_end   = (state_q == S_HDR) && (bit_idx_q == IDX_HEND);
    assign chk_end   = (state_q == S_CHK) && (bit_idx_q == IDX_CEND);
    assign alloc_end = (state_q == S_ALLOC) && (bit_idx_q == alloc_last);
    assign frame_end = (state_q == S_BODY) && (bit_idx_q == frame_last);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_HUNT:  if (sync_hit) state_d = S_HDR;
            S_HDR: begin
                if (layer_bad || fmt_bad) state_d = S_HUNT;
                else if (hdr_end)         state_d = prot_q ? S_ALLOC : S_CHK;
            end
            S_CHK:   if (chk_end)   state_d = S_ALLOC;
            S_ALLOC: if (alloc_end) state_d = S_BODY;
            S_BODY:  if (frame_end) state_d = S_HUNT;
            default: state_d = S_HUNT;
        endcase
    end

    // state register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= S_HUNT;
            bit_idx_q <= '0;
            ones_q    <= '0;
            byte_q    <= '0;
            prot_q    <= 1'b1;
            len_q     <= AW'(32);
            chk_q     <= '0;
            crc_bad_q <= 1'b0;
            wr_bank_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == S_HUNT && !sync_hit)
                ones_q <= bit_in ? ones_q + 4'd1 : 4'd0;
            else
                ones_q <= '0;
            if (sync_hit) begin
                bit_idx_q <= BW'(SYNC_ONES);
                byte_q    <= 7'b000_1111;
            end else if (state_q != S_HUNT) begin
                bit_idx_q <= bit_idx_q + BW'(1);
                byte_q    <= {byte_q[5:0], bit_in};
            end
            if (state_q == S_HDR && bit_idx_q == IDX_PROT)
                prot_q <= bit_in;
            if (state_q == S_HDR && bit_idx_q == IDX_PAD && len_ok)
                len_q <= len_bytes;
            if (state_q == S_CHK)
                chk_q <= {chk_q[14:0], bit_in};
            if (alloc_end)
                crc_bad_q <= !prot_q && (crc_next != chk_q);
            if (frame_end)
                wr_bank_q <= ~wr_bank_q;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_toggle <= 1'b0;
            crc_err      <= 1'b0;
            frame_bytes  <= '0;
        end else if (frame_end) begin
            frame_toggle <= ~frame_toggle;
            crc_err      <= crc_bad_q;
            frame_bytes  <= len_q;
        end
    end

    // frame buffer write path
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [7:0]    wr_data;

    always_comb begin
        wr_en   = sync_hit || ((state_q != S_HUNT) && (bit_idx_q[2:0] == 3'b111));
        wr_addr = sync_hit ? '0 : bit_idx_q[BW-1:3];
        wr_data = sync_hit ? 8'hFF : {byte_q, bit_in};
    end

    afc_pingpong_ram #(.BYTES(BUF_BYTES), .AW(AW)) u_ram (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_bank (wr_bank_q),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_bank (~wr_bank_q),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/afc_capture_checker.sv
module afc_capture_checker #(
    parameter int AW = 10
) (
    input logic                clk,
    input logic                rst_n,
    input afc_pkg::cap_state_t state,
    input logic                prot_q,
    input logic                frame_toggle,
    input logic                crc_err,
    input logic [AW-1:0]       frame_bytes
);
    import afc_pkg::*;

    assert_toggle_from_body_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_toggle != $past(frame_toggle)) |-> ($past(state) == S_BODY));

    assert_header_after_hunt_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == S_HDR) && ($past(state) != S_HDR)) |-> ($past(state) == S_HUNT));

    assert_len_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_bytes != '0) |-> ((frame_bytes[1:0] == 2'b00) && (frame_bytes >= AW'(32))
                                 && (frame_bytes <= AW'(676))));

    assert_err_with_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_err != $past(crc_err)) |-> (frame_toggle != $past(frame_toggle)));

    assert_no_chkword_unprot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_CHK) |-> !prot_q);
endmodule

bind audio_frame_capture afc_capture_checker #(.AW(AW)) u_afc_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .state        (state_q),
    .prot_q       (prot_q),
    .frame_toggle (frame_toggle),
    .crc_err      (crc_err),
    .frame_bytes  (frame_bytes)
);

// File: tb/audio_frame_capture_bench.sv
`timescale 1ns/1ps
module audio_frame_capture_bench;
    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bit_in = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    rd_data;
    logic          frame_toggle, crc_err;
    logic [AW-1:0] frame_bytes;

    audio_frame_capture u_audio_frame_capture (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .rd_addr(rd_addr),
        .rd_data(rd_data), .frame_toggle(frame_toggle), .crc_err(crc_err),
        .frame_bytes(frame_bytes)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    logic exp_tog = 1'b0;
    logic [7:0] fr  [1024];
    logic [7:0] prv [1024];
    int fr_len = 0, prv_len = 0;
    bit done = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_len(input int br, input int fs, input int pad);
        int hz;
        if (br == 0 || br == 15 || fs == 3) return 0;
        hz = (fs == 0) ? 44100 : (fs == 1) ? 48000 : 32000;
        return 4 * ((12 * br * 32000) / hz) + 4 * pad;
    endfunction

    function automatic logic [15:0] crc_bytes(input int first, input int last, input logic [15:0] c0);
        logic [15:0] c = c0;
        for (int i = first; i <= last; i++)
            for (int b = 7; b >= 0; b--) begin
                logic fb = c[15] ^ fr[i][b];
                c = {c[14:0], 1'b0} ^ (fb ? 16'h8005 : 16'h0000);
            end
        return c;
    endfunction

    task automatic build(input int br, input int fs, input int pad, input bit prot,
                         input bit bad_crc, input bit ff_tail);
        logic [15:0] c;
        fr_len = exp_len(br, fs, pad);
        for (int i = 4; i < fr_len; i++) fr[i] = 8'($urandom);
        fr[0] = 8'hFF;
        fr[1] = {4'hF, 1'b1, 2'b11, prot};
        fr[2] = {4'(br), 2'(fs), 1'(pad), 1'b0};
        fr[3] = {2'b11, 6'($urandom)};
        if (ff_tail) begin fr[fr_len-2] = 8'hFF; fr[fr_len-1] = 8'hFF; end
        if (!prot) begin
            c = crc_bytes(2, 3, 16'hFFFF);
            c = crc_bytes(6, 21, c);
            fr[4] = c[15:8];
            fr[5] = c[7:0] ^ {7'b0, bad_crc};
        end
    endtask

    task automatic zeros(input int n);
        for (int i = 0; i < n; i++) begin @(negedge clk); bit_in = 1'b0; end
    endtask

    // sends fr; optionally reads the previous frame during capture (R9)
    task automatic send(input int nbytes, input bit chkprev, output int bad);
        bad = 0;
        for (int i = 0; i < nbytes*8; i++) begin
            @(negedge clk);
            if (chkprev && i > 0 && ((i-1) % 8 == 0) && ((i-1)/8) < prv_len)
                if (rd_data !== prv[(i-1)/8]) bad++;
            if (chkprev && (i % 8 == 0) && (i/8) < prv_len) rd_addr = AW'(i/8);
            bit_in = fr[i/8][7 - (i % 8)];
        end
    endtask

    task automatic do_frame(input string req, input int br, input int fs, input int pad,
                            input bit prot, input bit bad_crc, input bit ff_tail,
                            input bit chkprev, input int gap);
        int bad;
        zeros(gap);
        build(br, fs, pad, prot, bad_crc, ff_tail);
        send(fr_len, chkprev, bad);
        @(posedge clk); #1;
        exp_tog = ~exp_tog;
        check(frame_toggle == exp_tog, "R2", {req, " toggle"}, int'(frame_toggle), int'(exp_tog));
        check(int'(frame_bytes) == fr_len, "R3", {req, " length"}, int'(frame_bytes), fr_len);
        check(crc_err == (!prot && bad_crc), prot ? "R8" : "R7", {req, " crc_err"},
              int'(crc_err), int'(!prot && bad_crc));
        if (chkprev) check(bad == 0, "R9", {req, " previous frame read during capture"}, bad, 0);
        for (int i = 0; i < fr_len; i++) prv[i] = fr[i];
        prv_len = fr_len;
    endtask

    task automatic readback(input string req);
        int bad = 0, first = -1;
        for (int a = 0; a <= prv_len; a++) begin
            @(negedge clk);
            bit_in = 1'b0;
            if (a > 0 && rd_data !== prv[a-1]) begin
                bad++;
                if (first < 0) first = a - 1;
            end
            if (a < prv_len) rd_addr = AW'(a);
        end
        check(bad == 0, req, "readback mismatching bytes (first index in actual)",
              (bad == 0) ? 0 : first, 0);
    endtask

    task automatic bad_header(input string req, input logic [1:0] layer,
                              input int br, input int fs);
        fr[0] = 8'hFF;
        fr[1] = {4'hF, 1'b1, layer, 1'b1};
        fr[2] = {4'(br), 2'(fs), 2'b00};
        fr[3] = 8'hC0;
        begin int b; send(4, 1'b0, b); end
        zeros(64);
        check(frame_toggle == exp_tog, req, "no toggle on rejected header",
              int'(frame_toggle), int'(exp_tog));
        check(int'(frame_bytes) == prv_len, req, "length unchanged", int'(frame_bytes), prv_len);
    endtask

    initial begin
        void'($urandom(32'h1234_5eed));
        repeat (4) @(negedge clk);
        // R1: reset values
        check(frame_toggle == 1'b0, "R1", "toggle at reset", int'(frame_toggle), 0);
        check(crc_err == 1'b0, "R1", "crc_err at reset", int'(crc_err), 0);
        check(frame_bytes == '0, "R1", "frame_bytes at reset", int'(frame_bytes), 0);
        rst_n = 1'b1;
        zeros(10);

        // R3/R4/R8: 128 kbit/s 44.1 kHz, unprotected -> 136 bytes
        do_frame("basic", 4, 0, 0, 1'b1, 1'b0, 1'b0, 1'b0, 5);
        readback("R4");
        // R7: protected, good check word
        do_frame("crc good", 4, 0, 0, 1'b0, 1'b0, 1'b0, 1'b0, 3);
        readback("R4");
        // R7: protected, corrupted check word
        do_frame("crc bad", 7, 1, 0, 1'b0, 1'b1, 1'b0, 1'b0, 0);
        // R3: padding adds 4 bytes
        do_frame("padded", 4, 0, 1, 1'b1, 1'b0, 1'b0, 1'b0, 7);
        readback("R4");
        // R5: wrong layer code, then a valid frame
        bad_header("R5", 2'b10, 4, 0);
        do_frame("after bad layer R5", 2, 2, 0, 1'b1, 1'b0, 1'b0, 1'b0, 0);
        // R6: illegal bitrate and rate codes
        bad_header("R6", 2'b11, 15, 0);
        bad_header("R6", 2'b11, 0, 1);
        bad_header("R6", 2'b11, 5, 3);
        // R9: back-to-back frames with reads of the previous bank
        do_frame("b2b A", 14, 2, 1, 1'b0, 1'b0, 1'b0, 1'b0, 2);
        do_frame("b2b B R9", 3, 0, 0, 1'b1, 1'b0, 1'b0, 1'b1, 0);
        do_frame("b2b C R9", 1, 1, 0, 1'b0, 1'b0, 1'b1, 1'b1, 0);
        // R10: previous frame ended in ones, next sync follows at once
        do_frame("after ones tail R10", 4, 0, 0, 1'b1, 1'b0, 1'b1, 1'b1, 0);
        do_frame("aligned R10", 6, 0, 1, 1'b0, 1'b0, 1'b0, 1'b1, 0);
        readback("R10");
        // random mix
        for (int k = 0; k < 10; k++) begin
            int br = 1 + int'($urandom_range(13));
            int fs = int'($urandom_range(2));
            int pd = int'($urandom_range(1));
            bit pr = 1'($urandom_range(1));
            bit bc = 1'($urandom_range(1));
            int gp = ($urandom_range(2) == 0) ? 0 : int'($urandom_range(20));
            do_frame("random", br, fs, pd, pr, bc, 1'($urandom_range(1)), gp == 0, gp);
            if (k % 3 == 0) readback("R4");
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0 (run did not finish)");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule